// File: doc/BRIEF.md
# Limit-Compare Counter Timer

This block is one counter/timer slice behind a small 32-bit register bus. An up-counter advances by one step on every cycle where the tick-enable input is high. The tick-enable is the already divided time base. Software programs a limit. When the next step would make the count equal to the limit, the count returns to zero, a sticky reached flag is set and a level interrupt goes high. A limit of zero makes the counter free-run over its whole range, and the event then fires on the wrap from all ones to zero.

The count and the limit sit in bits 30:9 of their register words, so one step is worth 512 in register units. Bits below 9 always read as zero. Word 0 holds the limit. A write to word 0 restarts the count, and a read of word 0 acknowledges the event. Word 1 reads back the live count with the reached flag in bit 31. Word 2 is a second way to write the limit, and it leaves the running count alone. The bus is a plain strobe interface with no back-pressure: a read is accepted in the cycle it is presented, and its data comes back registered one cycle later with a one-cycle valid pulse.

Top module: `lc_timer`

## Requirements
- R1: After reset the limit, the count, the reached flag, the interrupt and rd_vld are all zero, and the counter advances on tick_en straight away.
- R2: Each cycle with tick_en high adds one to the count, which reads back in bits 30:9 of word 1. Bits 8:0 of every read word are zero.
- R3: A write to word 0 stores bits 30:9 of bus_wdata as the limit, clears the count and lowers irq. A tick in the same cycle is discarded.
- R4: A write to word 2 stores the limit and leaves the count unchanged.
- R5: With a nonzero limit L, a tick that would bring the count to L sets the count to zero, sets reached and raises irq. Events therefore come every L ticks.
- R6: With limit zero, the count runs to all ones, and the next tick wraps it to zero, sets reached and raises irq.
- R7: If the count is already past a nonzero limit, the count runs on to the full-range wrap without an event, and the event comes when it next reaches the limit.
- R8: A read of word 0 returns the limit in bits 30:9 with all other bits zero, and it clears reached and irq. An event in the same cycle wins, so both stay set.
- R9: A read of word 1 returns reached in bit 31 and the count from before that edge in bits 30:9.
- R10: Writes to word 1 and word 3 have no effect. A read of word 3 returns zero.
- R11: rd_data and rd_vld are registered. rd_vld is high for exactly the cycle after a read, and rd_data holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One count step when high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 limit, 1 counter, 2 limit without restart, 3 unused |
| bus_wdata | input | 32 | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Every result is due one edge after its stimulus. The count, the flag, irq and the read data are each a single register away from the inputs. The bench applies each cycle's inputs on the falling edge and samples the outputs on the next falling edge, so every check sits half a period after the edge that produced it. Each cycle where a tick lands together with a limit write or a limit read is checked on that same following edge. The two long runs, the free-run wrap and the wrap past a stale limit, count their ticks exactly, so the event is expected on one known cycle.

// File: rtl/lc_timer_pkg.sv
package lc_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FLAG_BIT = 31;
  typedef enum logic [1:0] {
    W_LIMIT = 2'd0,
    W_COUNT = 2'd1,
    W_ALIAS = 2'd2,
    W_NONE  = 2'd3
  } word_e;
  typedef struct packed {
    logic rd_lim;
    logic rd_cnt;
    logic rd_any;
    logic wr_lim;
    logic wr_alias;
  } strobe_t;
endpackage

// File: rtl/lc_timer_decode.sv
module lc_timer_decode
  import lc_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  output strobe_t    stb
);
  word_e w;
  assign w = word_e'(bus_addr);

  always_comb begin
    stb          = '0;
    stb.rd_any   = bus_en && !bus_we;
    stb.rd_lim   = bus_en && !bus_we && (w == W_LIMIT);
    stb.rd_cnt   = bus_en && !bus_we && (w == W_COUNT);
    stb.wr_lim   = bus_en &&  bus_we && (w == W_LIMIT);
    stb.wr_alias = bus_en &&  bus_we && (w == W_ALIAS);
  end

  // R10: at most one register action per access
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.rd_lim, stb.rd_cnt, stb.wr_lim, stb.wr_alias}));
endmodule

// File: rtl/lc_timer_count.sv
module lc_timer_count #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_lim,
  input  logic             wr_alias,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic [CNT_W:0] nxt;
  logic           cmp_lim;
  logic           cmp_wrap;

  assign nxt      = {1'b0, cnt} + 1'b1;
  assign cmp_lim  = (lim != '0) && (nxt[CNT_W-1:0] == lim);
  assign cmp_wrap = (lim == '0) && nxt[CNT_W];
  assign hit      = tick_en && !wr_lim && (cmp_lim || cmp_wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else begin
      if (wr_lim || wr_alias) lim <= wr_val;
      if (wr_lim)        cnt <= '0;
      else if (hit)      cnt <= '0;
      else if (tick_en)  cnt <= nxt[CNT_W-1:0];
    end
  end

  // R3: a limit write restarts the count
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (cnt == '0));
  // R4: the alias keeps the count when no tick arrives
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alias && !tick_en) |=> $stable(cnt));
  // R6: full-range wrap in free-run
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_lim && lim == '0 && cnt == ALL1) |=> (cnt == '0));
  // R2: no tick, no access: count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_lim) |=> $stable(cnt));
endmodule

// File: rtl/lc_timer_flag.sv
module lc_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rd_lim,
  input  logic wr_lim,
  output logic reached,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (hit)         reached <= 1'b1;
      else if (rd_lim) reached <= 1'b0;
      if (hit)                   irq <= 1'b1;
      else if (rd_lim || wr_lim) irq <= 1'b0;
    end
  end

  // R5: an event sets both the flag and the interrupt
  a_r5_event: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (reached && irq));
  // R8: acknowledge by reading the limit
  a_r8_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !hit) |=> (!reached && !irq));
  // R3: a limit write drops the interrupt
  a_r3_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> !irq);
endmodule

// File: rtl/lc_timer.sv
module lc_timer
  import lc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned FRAC_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        rd_vld,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int unsigned TOP_BIT = FRAC_W + CNT_W;

  strobe_t          stb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             hit;
  logic             reached;
  logic [31:0]      cnt_word;
  logic [31:0]      lim_word;

  lc_timer_decode u_dec (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .stb(stb)
  );

  lc_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_lim(stb.wr_lim), .wr_alias(stb.wr_alias),
    .wr_val(bus_wdata[FRAC_W +: CNT_W]),
    .cnt(cnt), .lim(lim), .hit(hit)
  );

  lc_timer_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .rd_lim(stb.rd_lim), .wr_lim(stb.wr_lim),
    .reached(reached), .irq(irq)
  );

  always_comb begin
    lim_word = 32'(lim) << FRAC_W;
    cnt_word = 32'(cnt) << FRAC_W;
    cnt_word[FLAG_BIT] = reached;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= stb.rd_any;
      if (stb.rd_any) begin
        case (word_e'(bus_addr))
          W_LIMIT: rd_data <= lim_word;
          W_COUNT: rd_data <= cnt_word;
          default: rd_data <= '0;
        endcase
      end
    end
  end

  initial begin
    assert (TOP_BIT <= FLAG_BIT) else $error("count field overlaps flag bit");
  end

  // R11: read data valid exactly one cycle after a read
  a_r11_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> rd_vld);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> (!rd_vld && $stable(rd_data)));
  // R2: sub-tick bits never appear in read data
  a_r2_frac: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (rd_data[FRAC_W-1:0] == '0));
endmodule

// File: tb/test_lc_timer.sv
module test_lc_timer;
  localparam int unsigned CW = 10;
  localparam int unsigned MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lc_timer #(.CNT_W(CW), .FRAC_W(9)) i_lc_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_vld(rd_vld), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic        en;
    logic        we;
    logic [1:0]  a;
    logic [31:0] wd;
    logic        tk;
    logic        chk;
    logic [31:0] exp;
    logic        ei;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b1, 1'b1, 2'd0, 32'h600,      1'b0, 1'b0, 32'h0,        1'b0}, // R3 limit 3
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0}, // R2
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0}, // R2
    '{1'b1, 1'b0, 2'd1, 32'h0,        1'b0, 1'b1, 32'h400,      1'b0}, // R9 count 2
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b1}, // R5 event
    '{1'b1, 1'b0, 2'd1, 32'h0,        1'b0, 1'b1, 32'h80000000, 1'b1}, // R9 flag
    '{1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 1'b1, 32'h600,      1'b0}, // R8 ack
    '{1'b1, 1'b0, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0,        1'b0}, // R8 flag gone
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0}, // R2
    '{1'b1, 1'b1, 2'd2, 32'h1000,     1'b0, 1'b0, 32'h0,        1'b0}, // R4 limit 8
    '{1'b1, 1'b0, 2'd1, 32'h0,        1'b0, 1'b1, 32'h200,      1'b0}, // R4 count kept
    '{1'b1, 1'b1, 2'd1, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0,        1'b0}, // R10 ignored
    '{1'b1, 1'b0, 2'd1, 32'h0,        1'b0, 1'b1, 32'h200,      1'b0}, // R10 count kept
    '{1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 1'b1, 32'h1000,     1'b0}  // R4 limit read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic step(input logic en, input logic we, input logic [1:0] a,
                      input logic [31:0] wd, input logic tk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; tick_en = tk;
    @(negedge clk);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    step(1'b1, 1'b0, a, 32'h0, 1'b0);
    check(req, rd_data, exp);
  endtask

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    rst_n = 1'b1;
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rd_vld", {31'h0, rd_vld}, 32'h0);
    rd(2'd1, 32'h0, "R1 count");
    check("R11 rd_vld", {31'h0, rd_vld}, 32'h1);
    rd(2'd0, 32'h0, "R1 limit");
    step(1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    check("R11 rd_vld low", {31'h0, rd_vld}, 32'h0);
    check("R11 rd_data held", rd_data, 32'h0);
    idle_ticks(5);
    rd(2'd1, 32'hA00, "R1 R2 runs free");

    for (int k = 0; k < 14; k++) begin
      step(VEC[k].en, VEC[k].we, VEC[k].a, VEC[k].wd, VEC[k].tk);
      check($sformatf("table row %0d irq", k), {31'h0, irq}, {31'h0, VEC[k].ei});
      if (VEC[k].chk)
        check($sformatf("table row %0d data", k), rd_data, VEC[k].exp);
    end

    // R7: limit 1 while count is 1
    step(1'b1, 1'b1, 2'd2, 32'h200, 1'b0);
    idle_ticks(MAXC - 1);
    check("R7 no early event", {31'h0, irq}, 32'h0);
    rd(2'd1, 32'(MAXC) << 9, "R7 count at top");
    idle_ticks(1);
    check("R7 wrap without event", {31'h0, irq}, 32'h0);
    idle_ticks(1);
    check("R7 event at limit", {31'h0, irq}, 32'h1);

    // R8: acknowledge collides with a new event
    step(1'b1, 1'b0, 2'd0, 32'h0, 1'b1);
    check("R8 limit read data", rd_data, 32'h200);
    check("R8 event wins irq", {31'h0, irq}, 32'h1);
    rd(2'd1, 32'h80000000, "R8 event wins flag");
    rd(2'd0, 32'h200, "R8 ack");
    check("R8 irq low", {31'h0, irq}, 32'h0);

    // R3: limit write collides with a tick
    step(1'b1, 1'b1, 2'd0, 32'h400, 1'b1);
    check("R3 irq low", {31'h0, irq}, 32'h0);
    rd(2'd1, 32'h0, "R3 tick discarded");

    // R6: free-run over the full range
    step(1'b1, 1'b1, 2'd0, 32'h0, 1'b0);
    idle_ticks(MAXC);
    check("R6 no event before wrap", {31'h0, irq}, 32'h0);
    rd(2'd1, 32'(MAXC) << 9, "R6 count at top");
    idle_ticks(1);
    check("R6 wrap event irq", {31'h0, irq}, 32'h1);
    rd(2'd1, 32'h80000000, "R6 wrap count");

    // R10: unused word
    step(1'b1, 1'b1, 2'd3, 32'hFFFFFFFF, 1'b0);
    rd(2'd3, 32'h0, "R10 word 3 reads zero");
    rd(2'd0, 32'h0, "R10 limit untouched");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule